// File: doc/BRIEF.md
# Synchronous Serial Shift-In Controller

This block is the master side of a clocked serial receive link. It drives a serial clock to an external shift-register peripheral and samples that peripheral's single data line, assembling a word of 1 to 16 bits. A transfer begins with a one-cycle start command. The command carries a 2-bit mode, a bit count and the low and high durations of the serial clock, all measured in system clock cycles.

The mode decides two things. It sets whether each bit is taken just before its clock pulse or just after it, and whether the bits fill the word most-significant first or least-significant first. When the last pulse completes, the word is presented right-justified together with a single-cycle done strobe. A wider value, such as a 20-bit quantity made of a 4-bit and a 16-bit field, is read by issuing the next start in the same cycle that done is seen. The serial clock then stays low between the two fields and no pulse is lost.

Top module: `sync_shift_rx`

## Requirements
- R1: While reset is high and in the cycle after, `sclk`, `busy` and `done` are 0 and `rx_word` is 0.
- R2: A start seen while idle sets `busy` on the next cycle. `sclk` is low at the start of every transfer and remains low whenever `busy` is 0.
- R3: Each bit gets exactly one `sclk` pulse: low for `cfg_low` cycles, then high for `cfg_high` cycles, with a value of 0 acting as 1. `done` rises on the edge that lies n×(low+high) edges after the edge that accepted start, where n is the bit count.
- R4: Mode bit 1 selects the sampling point. With 0 (codes 0 and 1), `sdi` is taken on the edge where `sclk` rises. With 1 (codes 2 and 3), it is taken on the edge where `sclk` falls.
- R5: Mode bit 0 = 0 means MSB-first: each new bit enters bit 0 and earlier bits move up. For example, 4 bits of a 0xAF stream give 0xA.
- R6: Mode bit 0 = 1 means LSB-first: the k-th received bit lands in bit k-1, and the bits above the count are 0.
- R7: The count accepts 1 to 16. A `cfg_bits` value of 0, or any value above 16, runs 16 bits.
- R8: `done` is high for exactly one cycle and `busy` falls with it. `rx_word` changes only in the cycle `done` is high and holds afterwards.
- R9: A start seen while `busy` is 1 is ignored. The running transfer keeps its length and result.
- R10: Mode, count and both durations are captured at start. Changing those inputs during a transfer has no effect.
- R11: A start given in the cycle `done` is high is accepted. Two such fields read from one continuous peripheral stream concatenate with the first field as the high part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (used only when idle) |
| cfg_mode | input | 2 | Bit 1: sample after pulse; bit 0: LSB-first |
| cfg_bits | input | 5 | Bits to receive, 0 or >16 means 16 |
| cfg_low | input | 8 | Serial clock low time in cycles |
| cfg_high | input | 8 | Serial clock high time in cycles |
| sdi | input | 1 | Serial data from peripheral |
| sclk | output | 1 | Serial clock to peripheral |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle strobe, result valid |
| rx_word | output | 16 | Right-justified received word |

## Verification
The hardest case to reach from the ports is the sampling point. It only shows when the data line changes between the rise and the fall of `sclk`. To expose it, the bench models the peripheral. In before-pulse modes it shifts on each falling `sclk`. In after-pulse modes it shifts on each rising `sclk` and holds the inverse of the first bit before the first pulse, so a design sampling at the wrong edge returns a shifted word. Back-to-back fields are reached by raising start at the instant `done` is observed. Mid-transfer starts and input changes are injected a fixed number of cycles into a long transfer.

// File: rtl/sync_shift_rx_pkg.sv
package sync_shift_rx_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  // mode bit 1: sample after the pulse instead of before it
  function automatic logic mode_post(input logic [1:0] m);
    return m[1];
  endfunction

  // mode bit 0: least significant bit arrives first
  function automatic logic mode_lsb(input logic [1:0] m);
    return m[0];
  endfunction

endpackage

// File: rtl/sync_shift_rx_timer.sv
module sync_shift_rx_timer #(
  parameter int TIME_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [TIME_W-1:0] load_val,
  output logic              expired
);

  logic [TIME_W-1:0] cnt_q;

  // a phase of N cycles counts N-1 .. 0; a length of 0 behaves as 1
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= (load_val == '0) ? '0 : load_val - TIME_W'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - TIME_W'(1);
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sync_shift_rx_assembler.sv
module sync_shift_rx_assembler #(
  parameter int MAX_BITS = 16,
  parameter int IDX_W    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  logic                capture,
  input  logic                lsb_first,
  input  logic                din,
  input  logic [IDX_W-1:0]    bit_idx,
  output logic [MAX_BITS-1:0] word_d
);

  logic [MAX_BITS-1:0] word_q;
  logic [MAX_BITS-1:0] shift_src;

  for (genvar gi = 0; gi < MAX_BITS; gi++) begin : g_bit
    if (gi == 0) begin : g_lsb
      assign shift_src[gi] = din;
    end else begin : g_up
      assign shift_src[gi] = word_q[gi-1];
    end

    always_comb begin
      if (clear) begin
        word_d[gi] = 1'b0;
      end else if (!capture) begin
        word_d[gi] = word_q[gi];
      end else if (lsb_first) begin
        word_d[gi] = (bit_idx == IDX_W'(gi)) ? din : word_q[gi];
      end else begin
        word_d[gi] = shift_src[gi];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) word_q <= '0;
    else     word_q <= word_d;
  end

endmodule

// File: rtl/sync_shift_rx.sv
module sync_shift_rx
  import sync_shift_rx_pkg::*;
#(
  parameter int MAX_BITS = 16,
  parameter int TIME_W   = 8,
  parameter int CNT_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [1:0]          cfg_mode,
  input  logic [CNT_W-1:0]    cfg_bits,
  input  logic [TIME_W-1:0]   cfg_low,
  input  logic [TIME_W-1:0]   cfg_high,
  input  logic                sdi,
  output logic                sclk,
  output logic                busy,
  output logic                done,
  output logic [MAX_BITS-1:0] rx_word
);

  localparam int IDX_W = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(MAX_BITS);

  phase_e              phase_q;
  logic [1:0]          mode_q;
  logic [CNT_W-1:0]    left_q;
  logic [IDX_W-1:0]    idx_q;
  logic [TIME_W-1:0]   lo_q;
  logic [TIME_W-1:0]   hi_q;

  logic                accept;
  logic                lo_end;
  logic                hi_end;
  logic                last_bit;
  logic                capture;
  logic                tmr_load;
  logic [TIME_W-1:0]   tmr_val;
  logic                tmr_expired;
  logic [MAX_BITS-1:0] asm_word;
  logic [CNT_W-1:0]    req_cnt;

  assign req_cnt  = ((cfg_bits == '0) || (cfg_bits > FULL_CNT)) ? FULL_CNT : cfg_bits;
  assign accept   = (phase_q == PH_IDLE) && start;
  assign lo_end   = (phase_q == PH_LOW)  && tmr_expired;
  assign hi_end   = (phase_q == PH_HIGH) && tmr_expired;
  assign last_bit = (left_q == CNT_W'(1));
  assign capture  = (lo_end && !mode_post(mode_q)) || (hi_end && mode_post(mode_q));
  assign tmr_load = accept || lo_end || (hi_end && !last_bit);

  always_comb begin
    if (lo_end)      tmr_val = hi_q;
    else if (accept) tmr_val = cfg_low;
    else             tmr_val = lo_q;
  end

  sync_shift_rx_timer #(
    .TIME_W (TIME_W)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sync_shift_rx_assembler #(
    .MAX_BITS (MAX_BITS),
    .IDX_W    (IDX_W)
  ) u_asm (
    .clk       (clk),
    .rst       (rst),
    .clear     (accept),
    .capture   (capture),
    .lsb_first (mode_lsb(mode_q)),
    .din       (sdi),
    .bit_idx   (idx_q),
    .word_d    (asm_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      mode_q  <= '0;
      left_q  <= '0;
      idx_q   <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      sclk    <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      rx_word <= '0;
    end else begin
      done <= 1'b0;
      if (capture) idx_q <= idx_q + IDX_W'(1);
      unique case (phase_q)
        PH_IDLE: begin
          sclk <= 1'b0;
          if (start) begin
            mode_q  <= cfg_mode;
            left_q  <= req_cnt;
            idx_q   <= '0;
            lo_q    <= cfg_low;
            hi_q    <= cfg_high;
            busy    <= 1'b1;
            phase_q <= PH_LOW;
          end
        end
        PH_LOW: begin
          if (tmr_expired) begin
            sclk    <= 1'b1;
            phase_q <= PH_HIGH;
          end
        end
        PH_HIGH: begin
          if (tmr_expired) begin
            sclk <= 1'b0;
            if (last_bit) begin
              phase_q <= PH_IDLE;
              busy    <= 1'b0;
              done    <= 1'b1;
              rx_word <= asm_word;
            end else begin
              left_q  <= left_q - CNT_W'(1);
              phase_q <= PH_LOW;
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sync_shift_rx_checker.sv
module sync_shift_rx_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         sclk,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] rx_word
);

  AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sclk) else $error("idle clock high"); // R2

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy) else $error("start not taken"); // R2

  AST_PULSE_IN_TRANSFER: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> busy) else $error("pulse outside transfer"); // R3

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done too long"); // R8

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))) else $error("done without busy end"); // R8

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(rx_word)) else $error("result moved without done"); // R8

endmodule

bind sync_shift_rx sync_shift_rx_checker #(.W(MAX_BITS)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .sclk    (sclk),
  .busy    (busy),
  .done    (done),
  .rx_word (rx_word)
);

// File: tb/sync_shift_rx_bench.sv
`timescale 1ns/1ps
module sync_shift_rx_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  cfg_mode = '0;
  logic [4:0]  cfg_bits = '0;
  logic [7:0]  cfg_low = '0;
  logic [7:0]  cfg_high = '0;
  logic        sdi = 1'b0;
  logic        sclk;
  logic        busy;
  logic        done;
  logic [15:0] rx_word;

  int nchk = 0;
  int nerr = 0;
  int pulses = 0;

  always #2.5 clk = ~clk;

  sync_shift_rx u_sync_shift_rx (
    .clk (clk), .rst (rst), .start (start), .cfg_mode (cfg_mode),
    .cfg_bits (cfg_bits), .cfg_low (cfg_low), .cfg_high (cfg_high),
    .sdi (sdi), .sclk (sclk), .busy (busy), .done (done), .rx_word (rx_word)
  );

  // peripheral model: a shift register feeding sdi
  logic [31:0] pstream = '0;
  logic        post_tb = 1'b0;

  always @(posedge sclk) begin
    pulses++;
    if (post_tb) begin
      sdi = pstream[31];
      pstream = pstream << 1;
    end
  end

  always @(negedge sclk) begin
    if (!post_tb) begin
      pstream = pstream << 1;
      sdi = pstream[31];
    end
  end

  task automatic load_periph(input logic [1:0] m, input logic [31:0] s);
    pstream = s;
    post_tb = m[1];
    sdi     = m[1] ? ~s[31] : s[31];
    pulses  = 0;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {mode, bits, low, high, peripheral word, expected}
  localparam int NV = 9;
  localparam logic [54:0] VEC [0:NV-1] = '{
    {2'd0, 5'd8,  8'd2, 8'd5, 16'hAF00, 16'h00AF},  // R5 R4
    {2'd0, 5'd4,  8'd1, 8'd3, 16'hAF00, 16'h000A},  // R5
    {2'd1, 5'd8,  8'd3, 8'd2, 16'hAF00, 16'h00F5},  // R6
    {2'd2, 5'd8,  8'd2, 8'd3, 16'h3C00, 16'h003C},  // R4
    {2'd3, 5'd5,  8'd1, 8'd1, 16'hC800, 16'h0013},  // R6 R4
    {2'd0, 5'd16, 8'd1, 8'd2, 16'h1234, 16'h1234},  // R7
    {2'd3, 5'd16, 8'd2, 8'd1, 16'h0001, 16'h8000},  // R6 R7
    {2'd2, 5'd1,  8'd0, 8'd0, 16'h8000, 16'h0001},  // R3 zero lengths
    {2'd1, 5'd0,  8'd1, 8'd1, 16'hBEEF, 16'hF77D}   // R7 count 0
  };

  // disturb: 0 none, 1 extra start while busy, 2 change config while busy
  task automatic run_xfer(input logic [1:0] m, input logic [4:0] n, input logic [7:0] lo,
                          input logic [7:0] hi, input logic [15:0] word,
                          input logic [15:0] exp, input int disturb, input string tag);
    int cyc;
    int n_eff;
    int t_lo;
    int t_hi;
    logic [15:0] held;
    n_eff = (n == 0 || n > 16) ? 16 : int'(n);
    t_lo  = (lo == 0) ? 1 : int'(lo);
    t_hi  = (hi == 0) ? 1 : int'(hi);
    load_periph(m, {word, 16'h0});
    @(negedge clk);
    cfg_mode = m; cfg_bits = n; cfg_low = lo; cfg_high = hi; start = 1'b1;
    cyc = 0;
    do begin
      @(posedge clk); #1; cyc++;
      if (cyc == 1) begin
        start = 1'b0;
        check({tag, " R2 busy after start"}, busy, 1);
        check({tag, " R2 sclk low at start"}, sclk, 0);
      end
      if (cyc == 6 && disturb == 1) start = 1'b1;
      if (cyc == 7 && disturb == 1) start = 1'b0;
      if (cyc == 6 && disturb == 2) begin
        cfg_mode = ~m; cfg_bits = 5'd3; cfg_low = 8'd9; cfg_high = 8'd9;
      end
    end while (!done && cyc < 20000);
    check({tag, " result"}, rx_word, exp);
    check({tag, " R3 done cycle"}, cyc, n_eff * (t_lo + t_hi) + 1);
    check({tag, " R3 pulse count"}, pulses, n_eff);
    check({tag, " R8 busy low with done"}, busy, 0);
    held = rx_word;
    @(posedge clk); #1;
    check({tag, " R8 done single cycle"}, done, 0);
    repeat (3) @(posedge clk); #1;
    check({tag, " R8 result holds"}, rx_word, held);
    check({tag, " R2 idle sclk low"}, sclk, 0);
  endtask

  initial begin
    #1000000;
    nerr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int cyc;
    logic [15:0] hi_field;
    repeat (3) @(posedge clk);
    #1;
    check("R1 sclk in reset", sclk, 0);
    check("R1 busy in reset", busy, 0);
    check("R1 done in reset", done, 0);
    check("R1 word in reset", rx_word, 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check("R1 idle after reset", {sclk, busy, done}, 0);

    for (int i = 0; i < NV; i++) begin
      run_xfer(VEC[i][54:53], VEC[i][52:48], VEC[i][47:40], VEC[i][39:32],
               VEC[i][31:16], VEC[i][15:0], 0, $sformatf("vec%0d R4/R5/R6", i));
    end

    // R9: extra start mid-transfer must not restart or reconfigure
    run_xfer(2'd0, 5'd8, 8'd2, 8'd2, 16'hAF00, 16'h00AF, 1, "R9 start while busy");
    // R10: inputs changed mid-transfer must not matter
    run_xfer(2'd0, 5'd8, 8'd2, 8'd2, 16'hAF00, 16'h00AF, 2, "R10 latched config");
    run_xfer(2'd3, 5'd8, 8'd1, 8'd2, 16'h5A00, 16'h005A, 2, "R10 latched lsb post");

    // R11: 4-bit then 16-bit field from one stream, back to back
    load_periph(2'd0, {20'hABCDE, 12'h0});
    @(negedge clk);
    cfg_mode = 2'd0; cfg_bits = 5'd4; cfg_low = 8'd1; cfg_high = 8'd2; start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    cyc = 0;
    do begin @(posedge clk); #1; cyc++; end while (!done && cyc < 20000);
    hi_field = rx_word;
    check("R11 first field", hi_field, 16'h000A);
    cfg_bits = 5'd16; start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    check("R11 chained start accepted", busy, 1);
    check("R11 sclk low between fields", sclk, 0);
    cyc = 0;
    do begin @(posedge clk); #1; cyc++; end while (!done && cyc < 20000);
    check("R11 combined value", {hi_field[3:0], rx_word}, 20'hABCDE);
    check("R11 total pulses", pulses, 20);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule